// File: doc/BRIEF.md
# Identification Register Read Port

This block is a read-only bank of 64-bit identification words. Software picks a word by a small index and reads it through an indirect read port. The port answers one clock later with a valid strobe and either the word or a reserved-register fault. The bank describes its own size. The low byte of word 3 gives the highest index that is implemented. Any index above that value faults instead of returning data.

The contents are fixed when the block is elaborated:
- Words 0 and 1 hold an ASCII vendor name.
- Word 2 always reads as zero.
- Word 3 carries version fields.
- Word 4 carries feature flags.
- Words 5 and above form a variable region tagged by a parameter.

A second port answers a single-bit query against the upper 32 bits of the feature word with no clock delay. Code that needs a fast feature check uses this port. Nothing can write the bank. A write request is dropped and flagged one cycle later.

Top module: `idreg_bank`

## Requirements
- R1: Words 0 and 1 together hold the vendor name as 16 bytes. Character k of the name is in byte k, where bytes 0–7 are word 0 bits 8k+7:8k and bytes 8–15 are word 1. Bytes past the end of the name are zero.
- R2: A read of index 2 returns all zeros with no fault.
- R3: Word 3 is laid out as follows:
  - bits 7:0 are the highest implemented index, which is the `LAST_IDX` parameter clamped to at least 4;
  - bits 15:8 are the revision;
  - bits 23:16 are the model;
  - bits 31:24 are the family;
  - bits 39:32 are the architecture revision;
  - bits 63:40 are zero.
- R4: Word 4 carries the feature flags at bits 0–3 (long branch, spontaneous deferral, 16-byte atomics, utilisation counter) and bits 32–33 (count-leading-zeros, 4-byte multiply). All other bits read zero, even when the parameters set them.
- R5: Each word k from 5 up to the highest index reads `{VAR_TAG[31:0], 24'h0, k[7:0]}`.
- R6: A read whose index is greater than the highest index returns `rsp_fault`=1 with `rsp_data`=0. A read at exactly the highest index does not fault.
- R7: `rsp_valid` is high in the cycle after each cycle in which `rd_req` is high, and low otherwise. When `rsp_valid` is low, `rsp_data` and `rsp_fault` are zero.
- R8: A write request raises `wr_reject` in the following cycle. No read result changes because of a write.
- R9: `tf_hit` equals bit 32+`tf_bit_sel` of word 4 in the same cycle.
- R10: While reset is active and directly after it, `rsp_valid`, `rsp_fault`, `rsp_data` and `wr_reject` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_req | input | 1 | Indirect read request |
| rd_idx | input | 8 | Word index for the read |
| wr_req | input | 1 | Write attempt (always refused) |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 64 | Read response word |
| rsp_fault | output | 1 | Reserved-register fault for the response |
| wr_reject | output | 1 | Write attempt refused |
| tf_bit_sel | input | 5 | Bit index into upper half of word 4 |
| tf_hit | output | 1 | Selected feature bit |

## Verification
The boundary between the highest index and the one above it is hit on purpose. A design with an off-by-one in the compare would either fault on the last word or leak data from a nonexistent one. The feature parameters are driven with every reserved bit set, so a mask that is missing shows up as stray ones in word 4 or on `tf_hit`. A vendor name shorter than 16 bytes checks both the byte order and the zero padding; a reversed packing would show the name backwards. Writes are interleaved with reads so that any state changed by a write would show up in later reads.

// File: rtl/idreg_pkg.sv
package idreg_pkg;

  localparam int WORD_W  = 64;
  localparam int IDX_W   = 8;
  localparam int TF_W    = 5;
  localparam int FIX_TOP = 4;

  localparam logic [WORD_W-1:0] FEAT_KEEP = 64'h0000_0003_0000_000F;

  // Left-justify a right-justified literal so character 0 lands in byte 0.
  function automatic logic [127:0] pack_vendor(input logic [127:0] lit);
    logic [127:0] o;
    int           k;
    bit           started;
    o       = '0;
    k       = 0;
    started = 1'b0;
    for (int j = 15; j >= 0; j--) begin
      if (lit[8*j +: 8] != 8'h00) started = 1'b1;
      if (started) begin
        o[8*k +: 8] = lit[8*j +: 8];
        k++;
      end
    end
    return o;
  endfunction

  function automatic logic [WORD_W-1:0] version_word(
      input logic [7:0] last, input logic [7:0] rev, input logic [7:0] mdl,
      input logic [7:0] fam, input logic [7:0] arch);
    return {24'h0, arch, fam, mdl, rev, last};
  endfunction

  function automatic logic [WORD_W-1:0] feature_word(
      input logic [31:0] lo, input logic [31:0] hi);
    return {hi, lo} & FEAT_KEEP;
  endfunction

  function automatic logic [WORD_W-1:0] var_word(
      input logic [31:0] tag, input logic [7:0] idx);
    return {tag, 24'h0, idx};
  endfunction

endpackage

// File: rtl/idreg_rom.sv
module idreg_rom
  import idreg_pkg::*;
#(
  parameter int                LAST     = 4,
  parameter logic [127:0]      VENDOR   = '0,
  parameter logic [7:0]        REVISION = 8'h0,
  parameter logic [7:0]        MODEL    = 8'h0,
  parameter logic [7:0]        FAMILY   = 8'h0,
  parameter logic [7:0]        ARCH_REV = 8'h0,
  parameter logic [31:0]       FEAT_LO  = 32'h0,
  parameter logic [31:0]       FEAT_HI  = 32'h0,
  parameter logic [31:0]       VAR_TAG  = 32'h0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] word,
  output logic              out_of_range
);

  localparam int           NWORDS  = LAST + 1;
  localparam logic [127:0] VPACK   = pack_vendor(VENDOR);
  localparam logic [7:0]   LAST_B  = 8'(LAST);

  logic [WORD_W-1:0] bank [NWORDS];

  assign bank[0] = VPACK[63:0];
  assign bank[1] = VPACK[127:64];
  assign bank[2] = '0;
  assign bank[3] = version_word(LAST_B, REVISION, MODEL, FAMILY, ARCH_REV);
  assign bank[4] = feature_word(FEAT_LO, FEAT_HI);

  genvar g;
  generate
    for (g = FIX_TOP + 1; g < NWORDS; g++) begin : g_var
      assign bank[g] = var_word(VAR_TAG, 8'(g));
    end
  endgenerate

  assign out_of_range = (idx > LAST_B);

  always_comb begin
    word = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (idx == IDX_W'(i)) word = bank[i];
    end
  end

endmodule

// File: rtl/idreg_resp_reg.sv
module idreg_resp_reg
  import idreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              fault_in,
  input  logic [WORD_W-1:0] word_in,
  input  logic              wr_req,
  output logic              valid,
  output logic              fault,
  output logic [WORD_W-1:0] data,
  output logic              wr_reject
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid     <= 1'b0;
      fault     <= 1'b0;
      data      <= '0;
      wr_reject <= 1'b0;
    end else begin
      valid     <= req;
      fault     <= req & fault_in;
      data      <= (req && !fault_in) ? word_in : '0;
      wr_reject <= wr_req;
    end
  end

endmodule

// File: rtl/idreg_feature_probe.sv
module idreg_feature_probe
  import idreg_pkg::*;
(
  input  logic [WORD_W-1:0] feat_word,
  input  logic [TF_W-1:0]   sel,
  output logic              hit
);

  logic [31:0] upper;
  assign upper = feat_word[WORD_W-1:32];
  assign hit   = upper[sel];

endmodule

// File: rtl/idreg_bank.sv
module idreg_bank
  import idreg_pkg::*;
#(
  parameter int           LAST_IDX = 6,
  parameter logic [127:0] VENDOR   = "GenericCoreCo",
  parameter logic [7:0]   REVISION = 8'h02,
  parameter logic [7:0]   MODEL    = 8'h11,
  parameter logic [7:0]   FAMILY   = 8'h1F,
  parameter logic [7:0]   ARCH_REV = 8'h01,
  parameter logic [31:0]  FEAT_LO  = 32'h0000_000F,
  parameter logic [31:0]  FEAT_HI  = 32'h0000_0003,
  parameter logic [31:0]  VAR_TAG  = 32'h5EED_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_req,
  input  logic [7:0]  rd_idx,
  input  logic        wr_req,
  output logic        rsp_valid,
  output logic [63:0] rsp_data,
  output logic        rsp_fault,
  output logic        wr_reject,
  input  logic [4:0]  tf_bit_sel,
  output logic        tf_hit
);

  localparam int LAST_LO  = (LAST_IDX < FIX_TOP) ? FIX_TOP : LAST_IDX;
  localparam int LAST_EFF = (LAST_LO > 255) ? 255 : LAST_LO;

  logic [WORD_W-1:0] lookup_word;
  logic              lookup_fault;
  logic [WORD_W-1:0] feat_word;

  assign feat_word = feature_word(FEAT_LO, FEAT_HI);

  idreg_rom #(
    .LAST(LAST_EFF), .VENDOR(VENDOR), .REVISION(REVISION), .MODEL(MODEL),
    .FAMILY(FAMILY), .ARCH_REV(ARCH_REV), .FEAT_LO(FEAT_LO),
    .FEAT_HI(FEAT_HI), .VAR_TAG(VAR_TAG)
  ) u_rom (
    .idx(rd_idx), .word(lookup_word), .out_of_range(lookup_fault)
  );

  idreg_resp_reg u_resp (
    .clk(clk), .rst_n(rst_n), .req(rd_req), .fault_in(lookup_fault),
    .word_in(lookup_word), .wr_req(wr_req), .valid(rsp_valid),
    .fault(rsp_fault), .data(rsp_data), .wr_reject(wr_reject)
  );

  idreg_feature_probe u_probe (
    .feat_word(feat_word), .sel(tf_bit_sel), .hit(tf_hit)
  );

endmodule

// File: rtl/idreg_bank_sva.sv
module idreg_bank_sva #(
  parameter int LAST = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_req,
  input logic [7:0]  rd_idx,
  input logic        wr_req,
  input logic        rsp_valid,
  input logic [63:0] rsp_data,
  input logic        rsp_fault,
  input logic        wr_reject,
  input logic [4:0]  tf_bit_sel,
  input logic        tf_hit,
  input logic        lookup_fault
);

  p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rsp_valid);
  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rsp_valid);
  p_quiet_when_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_data == 64'h0 && !rsp_fault));
  p_fault_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_data == 64'h0 && rsp_valid));
  p_fault_on_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_idx > 8'(LAST)) |=> rsp_fault);
  p_lookup_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && lookup_fault) |=> rsp_fault);
  p_last_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_idx == 8'(LAST)) |=> !rsp_fault);
  p_zero_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_idx == 8'd2) |=> (rsp_data == 64'h0 && !rsp_fault));
  p_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req |=> wr_reject);
  p_no_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req |=> !wr_reject);
  p_tf_reserved_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tf_bit_sel > 5'd1) |-> !tf_hit);

endmodule

bind idreg_bank idreg_bank_sva #(.LAST(LAST_EFF)) u_sva (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx(rd_idx),
  .wr_req(wr_req), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
  .rsp_fault(rsp_fault), .wr_reject(wr_reject), .tf_bit_sel(tf_bit_sel),
  .tf_hit(tf_hit), .lookup_fault(lookup_fault)
);

// File: tb/idreg_bank_test.sv
`timescale 1ns/1ps
module idreg_bank_test;

  localparam int           LAST   = 7;
  localparam logic [127:0] VLIT   = "UnitVendorName";
  localparam logic [31:0]  FLO    = 32'hFFFF_FFF5;
  localparam logic [31:0]  FHI    = 32'hFFFF_FFFE;
  localparam logic [31:0]  TAG    = 32'hC0DE_5A11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_req = 1'b0;
  logic [7:0]  rd_idx = 8'h0;
  logic        wr_req = 1'b0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        rsp_fault;
  logic        wr_reject;
  logic [4:0]  tf_bit_sel = 5'h0;
  logic        tf_hit;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  idreg_bank #(
    .LAST_IDX(LAST), .VENDOR(VLIT), .REVISION(8'h3C), .MODEL(8'hA5),
    .FAMILY(8'h07), .ARCH_REV(8'h92), .FEAT_LO(FLO), .FEAT_HI(FHI),
    .VAR_TAG(TAG)
  ) uut (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_idx(rd_idx),
    .wr_req(wr_req), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_fault(rsp_fault), .wr_reject(wr_reject), .tf_bit_sel(tf_bit_sel),
    .tf_hit(tf_hit)
  );

  function automatic logic [63:0] exp_word(input int idx);
    string       s;
    logic [127:0] v;
    s = "UnitVendorName";
    v = '0;
    for (int k = 0; k < s.len(); k++) v[8*k +: 8] = s[k];
    case (idx)
      0: return v[63:0];
      1: return v[127:64];
      2: return 64'h0;
      3: return 64'h0000_0092_07A5_3C07;
      4: return 64'h0000_0002_0000_0005;
      default: return {TAG, 24'h0, 8'(idx)};
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Issue a read at a negedge; the response is sampled at the following negedge.
  task automatic do_read(input logic [7:0] idx, input logic wr, input string req);
    logic        efault;
    logic [63:0] edata;
    @(negedge clk);
    rd_req = 1'b1;
    rd_idx = idx;
    wr_req = wr;
    @(negedge clk);
    rd_req = 1'b0;
    wr_req = 1'b0;
    efault = (int'(idx) > LAST);
    edata  = efault ? 64'h0 : exp_word(int'(idx));
    check({req, " valid R7"}, 64'(rsp_valid), 64'h1);
    check({req, " fault R6"}, 64'(rsp_fault), 64'(efault));
    check({req, " data"}, rsp_data, edata);
    check({req, " reject R8"}, 64'(wr_reject), 64'(wr));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid in reset", 64'(rsp_valid), 64'h0);
    check("R10 data in reset", rsp_data, 64'h0);
    check("R10 reject in reset", 64'(wr_reject), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 valid after reset", 64'(rsp_valid), 64'h0);
    check("R10 fault after reset", 64'(rsp_fault), 64'h0);

    do_read(8'd0, 1'b0, "R1 vendor lo");
    do_read(8'd1, 1'b0, "R1 vendor hi");
    do_read(8'd2, 1'b0, "R2 zero word");
    do_read(8'd3, 1'b0, "R3 version");
    do_read(8'd4, 1'b0, "R4 features");
    do_read(8'd5, 1'b0, "R5 variable first");
    do_read(8'(LAST), 1'b0, "R6 last index");
    do_read(8'(LAST + 1), 1'b0, "R6 first beyond");
    do_read(8'hFF, 1'b0, "R6 max index");
    do_read(8'd4, 1'b1, "R8 write with read");

    // R7: idle cycle after a read
    @(negedge clk);
    check("R7 idle valid", 64'(rsp_valid), 64'h0);
    check("R7 idle data", rsp_data, 64'h0);

    // R9: feature probe, combinational
    for (int b = 0; b < 32; b++) begin
      tf_bit_sel = 5'(b);
      #1;
      check("R9 tf bit", 64'(tf_hit), 64'(b == 1));
    end

    // R8: write alone, then read word 3 unchanged
    @(negedge clk);
    wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    check("R8 lone reject", 64'(wr_reject), 64'h1);
    check("R8 no response", 64'(rsp_valid), 64'h0);
    do_read(8'd3, 1'b0, "R8 after write");

    // Random mix of reads and writes
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ix;
      ix = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 12);
      do_read(ix, 1'($urandom), "R5 random");
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule